// File: doc/BRIEF.md
# Variable-Precision Fixed-Point Unpacker

This block sits between a narrow memory port and one lane of a fixed-width compute pipeline. Memory holds signed fixed-point values stored with only P bits each (P chosen at run time from 1 to 16). The values are packed back to back with no padding, so a value may start in one 16-bit word and end in the next. The unpacker accepts that word stream and hands the lane one full 16-bit fixed-point value per cycle. Each value is placed at a configurable binary-point offset, with zeros below it and copies of its sign bit above it.

Two 16-bit halves form a 32-bit staging register. Words fill the halves in turn, and a rotator driven by a 5-bit read pointer brings the current field to bit 0. A field may cross the seam between the halves or wrap from bit 31 back to bit 0. Every control decision (pointer, half flags, rotate amount) comes from P and the handshakes, never from data. A set of lanes could therefore share one copy of the control section.

A one-cycle start pulse clears the stream state and captures the configuration for the stream that follows.

Top module: `varprec_unpack`

## Requirements
- R1: After reset, and in the cycle after a start pulse, `out_valid` is 0 and `in_ready` is 1.
- R2: Value k of a stream occupies stream bits k*P to k*P+P-1, and word j of the stream supplies stream bits 16*j to 16*j+15 (bit 0 of a word is its lowest stream bit). Values leave in stream order, one per output handshake, and none is lost or repeated.
- R3: P is `cfg_len_m1`+1 and the placement offset is `cfg_shift`. Both are captured only in a cycle where `start` is 1. Changing those inputs at any other time has no effect on the values produced.
- R4: A value whose bits span bit 15 and bit 16 of the staging register (two consecutive words) is delivered correctly.
- R5: A value whose bits wrap from staging bit 31 to bit 0 is delivered correctly.
- R6: Output bit i is 0 for i < S, is field bit i-S for S <= i < S+P, and is the field's top bit for i >= S+P. S is the captured offset, and bits above 15 are dropped.
- R7: A half accepts a new word only after all of its bits have been consumed. When both halves hold unconsumed bits and the output slot is full, `in_ready` is 0. Words presented meanwhile are not taken, and none is lost.
- R8: A value is not output until every one of its P bits has been loaded. The output stays invalid while the next value still needs a word that has not arrived.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_val` hold unchanged.
- R10: `out_valid` rises at the clock edge after the edge that accepted the last word a value needs. Given enough input, values follow on consecutive cycles while `out_ready` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Clears stream state and captures configuration |
| cfg_len_m1 | input | 4 | Stored width minus one (P-1) |
| cfg_shift | input | 4 | Bit position of the field's LSB within the output |
| in_word | input | 16 | Packed memory word |
| in_valid | input | 1 | Word available |
| in_ready | output | 1 | Word will be taken at the next edge |
| out_val | output | 16 | Expanded fixed-point value |
| out_valid | output | 1 | Output value available |
| out_ready | input | 1 | Consumer takes the value at the next edge |

## Verification
Every result is due at a fixed edge. A word accepted at edge n makes `in_ready` change after edge n. Any value completed by that word appears on `out_val` after edge n+1. A value held under back-pressure must be unchanged at the next sample. The bench drives all inputs and reads all outputs at the falling edge. It decides whether a handshake takes place from the values sampled there, so every check lands half a cycle after the edge that produced the result. The latency, stall and no-early-output checks count falling edges from the accepting edge and compare at exactly the edge computed above.

// File: rtl/vpu_pkg.sv
package vpu_pkg;
  // width of one memory word and of one expanded output value
  localparam int unsigned WORD_W  = 16;
  // two halves make the staging register
  localparam int unsigned HALVES  = 2;
  localparam int unsigned STAGE_W = HALVES * WORD_W;
  localparam int unsigned PTR_W   = $clog2(STAGE_W);
  localparam int unsigned LEN_W   = $clog2(WORD_W);
endpackage

// File: rtl/vp_unpack_ctrl.sv
// Data-independent control: read pointer, half-occupancy flags, load order
// and the captured configuration. One instance can steer many lanes.
module vp_unpack_ctrl #(
  parameter  int WORD_W  = vpu_pkg::WORD_W,
  localparam int STAGE_W = 2 * WORD_W,
  localparam int PTR_W   = $clog2(STAGE_W),
  localparam int LEN_W   = $clog2(WORD_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [LEN_W-1:0] cfg_len_m1,
  input  logic [LEN_W-1:0] cfg_shift,
  input  logic             in_valid,
  input  logic             slot_free,
  output logic             in_ready,
  output logic             load_en,
  output logic             load_half,
  output logic             take,
  output logic [PTR_W-1:0] ptr,
  output logic [LEN_W-1:0] len_q,
  output logic [LEN_W-1:0] shift_q
);

  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] ptr_last;
  logic [PTR_W-1:0] ptr_nxt;
  logic [PTR_W-1:0] step;
  logic [1:0]       full_q;
  logic             ld_sel_q;
  logic             have_all;
  logic             leave;

  assign step     = PTR_W'(len_q) + PTR_W'(1);
  assign ptr_last = ptr_q + PTR_W'(len_q);
  assign ptr_nxt  = ptr_q + step;

  // both the half holding the first bit and the one holding the last bit
  assign have_all = full_q[ptr_q[PTR_W-1]] && full_q[ptr_last[PTR_W-1]];
  assign take     = have_all && slot_free;
  assign leave    = take && (ptr_nxt[PTR_W-1] != ptr_q[PTR_W-1]);

  assign in_ready  = !full_q[ld_sel_q];
  assign load_en   = in_valid && in_ready;
  assign load_half = ld_sel_q;
  assign ptr       = ptr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q   <= '1;
      shift_q <= '0;
    end else if (start) begin
      len_q   <= cfg_len_m1;
      shift_q <= cfg_shift;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || start) begin
      ptr_q    <= '0;
      full_q   <= '0;
      ld_sel_q <= 1'b0;
    end else begin
      if (load_en) ld_sel_q <= ~ld_sel_q;
      if (take)    ptr_q    <= ptr_nxt;
      for (int h = 0; h < 2; h++) begin
        if (load_en && (ld_sel_q == 1'(h)))
          full_q[h] <= 1'b1;
        else if (leave && (ptr_q[PTR_W-1] == 1'(h)))
          full_q[h] <= 1'b0;
      end
    end
  end

  // R1
  start_clear_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> (in_ready && !take));

endmodule

// File: rtl/vp_unpack_stage.sv
// Staging register: two word-wide halves, written alternately.
module vp_unpack_stage #(
  parameter  int WORD_W  = vpu_pkg::WORD_W,
  localparam int STAGE_W = 2 * WORD_W
) (
  input  logic               clk,
  input  logic               load_en,
  input  logic               load_half,
  input  logic [WORD_W-1:0]  word,
  output logic [STAGE_W-1:0] stage
);

  for (genvar h = 0; h < 2; h++) begin : g_half
    logic [WORD_W-1:0] half_q;
    always_ff @(posedge clk) begin
      if (load_en && (load_half == 1'(h)))
        half_q <= word;
    end
    assign stage[h*WORD_W +: WORD_W] = half_q;
  end

endmodule

// File: rtl/vp_unpack_align.sv
// Rotates the staging register so the current field sits at bit 0,
// expands it to a full word at the chosen offset and registers it.
module vp_unpack_align #(
  parameter  int WORD_W  = vpu_pkg::WORD_W,
  localparam int STAGE_W = 2 * WORD_W,
  localparam int PTR_W   = $clog2(STAGE_W),
  localparam int LEN_W   = $clog2(WORD_W)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [STAGE_W-1:0] stage,
  input  logic [PTR_W-1:0]   ptr,
  input  logic [LEN_W-1:0]   len_m1,
  input  logic [LEN_W-1:0]   shift,
  input  logic               take,
  input  logic               out_ready,
  output logic               out_valid,
  output logic [WORD_W-1:0]  out_val
);

  logic [2*STAGE_W-1:0] dbl;
  logic [2*STAGE_W-1:0] shr;
  logic [WORD_W-1:0]    low;
  logic [LEN_W:0]       plen;
  logic [WORD_W:0]      mask_w;
  logic [WORD_W-1:0]    mask;
  logic [WORD_W-1:0]    fld;
  logic [WORD_W-1:0]    sx;
  logic [WORD_W-1:0]    ext;
  logic                 sign;

  // circular rotate right by the pointer
  assign dbl = {stage, stage};
  assign shr = dbl >> ptr;
  assign low = shr[WORD_W-1:0];

  assign plen   = {1'b0, len_m1} + (LEN_W+1)'(1);
  assign mask_w = ((WORD_W+1)'(1) << plen) - (WORD_W+1)'(1);
  assign mask   = mask_w[WORD_W-1:0];
  assign sign   = low[len_m1];
  assign fld    = low & mask;
  assign sx     = sign ? (fld | ~mask) : fld;
  assign ext    = sx << shift;

  always_ff @(posedge clk) begin
    if (rst || start) begin
      out_valid <= 1'b0;
      out_val   <= '0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        out_val   <= ext;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R6
  low_fill_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((out_val & ((WORD_W'(1) << shift) - WORD_W'(1))) == '0));

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && !start) |=> (out_valid && $stable(out_val)));

endmodule

// File: rtl/varprec_unpack.sv
module varprec_unpack #(
  parameter  int WORD_W  = vpu_pkg::WORD_W,
  localparam int STAGE_W = 2 * WORD_W,
  localparam int PTR_W   = $clog2(STAGE_W),
  localparam int LEN_W   = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [LEN_W-1:0]  cfg_len_m1,
  input  logic [LEN_W-1:0]  cfg_shift,
  input  logic [WORD_W-1:0] in_word,
  input  logic              in_valid,
  output logic              in_ready,
  output logic [WORD_W-1:0] out_val,
  output logic              out_valid,
  input  logic              out_ready
);

  logic               load_en;
  logic               load_half;
  logic               take;
  logic               slot_free;
  logic [PTR_W-1:0]   ptr;
  logic [LEN_W-1:0]   len_q;
  logic [LEN_W-1:0]   shift_q;
  logic [STAGE_W-1:0] stage;

  assign slot_free = !out_valid || out_ready;

  vp_unpack_ctrl #(.WORD_W(WORD_W)) ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .cfg_len_m1(cfg_len_m1),
    .cfg_shift (cfg_shift),
    .in_valid  (in_valid),
    .slot_free (slot_free),
    .in_ready  (in_ready),
    .load_en   (load_en),
    .load_half (load_half),
    .take      (take),
    .ptr       (ptr),
    .len_q     (len_q),
    .shift_q   (shift_q)
  );

  vp_unpack_stage #(.WORD_W(WORD_W)) stage_i (
    .clk      (clk),
    .load_en  (load_en),
    .load_half(load_half),
    .word     (in_word),
    .stage    (stage)
  );

  vp_unpack_align #(.WORD_W(WORD_W)) align_i (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .stage    (stage),
    .ptr      (ptr),
    .len_m1   (len_q),
    .shift    (shift_q),
    .take     (take),
    .out_ready(out_ready),
    .out_valid(out_valid),
    .out_val  (out_val)
  );

  // bit accounting seen only at the two handshakes
  logic [31:0] loaded_bits_q;
  logic [31:0] used_bits_q;
  logic [31:0] p_bits;

  assign p_bits = 32'(len_q) + 32'd1;

  always_ff @(posedge clk) begin
    if (rst || start) begin
      loaded_bits_q <= '0;
      used_bits_q   <= '0;
    end else begin
      if (in_valid && in_ready)   loaded_bits_q <= loaded_bits_q + 32'(WORD_W);
      if (out_valid && out_ready) used_bits_q   <= used_bits_q + p_bits;
    end
  end

  // R7
  bit_budget_chk: assert property (@(posedge clk) disable iff (rst)
    (used_bits_q <= loaded_bits_q) &&
    ((loaded_bits_q - used_bits_q) <= 32'(3 * WORD_W)));

  // R8
  field_loaded_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (loaded_bits_q >= used_bits_q + p_bits));

endmodule

// File: tb/varprec_unpack_tb_top.sv
module varprec_unpack_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic [3:0]  cfg_len_m1;
  logic [3:0]  cfg_shift;
  logic [15:0] in_word;
  logic        in_valid;
  logic        in_ready;
  logic [15:0] out_val;
  logic        out_valid;
  logic        out_ready;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  logic [15:0] vals  [0:63];
  logic [15:0] words [0:63];
  bit          sbits [0:1023];
  int          nvals;
  int          nwords;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  varprec_unpack dut_i (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .cfg_len_m1(cfg_len_m1),
    .cfg_shift (cfg_shift),
    .in_word   (in_word),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_val   (out_val),
    .out_valid (out_valid),
    .out_ready (out_ready)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] expand(input logic [15:0] v, input int p, input int sh);
    logic [15:0] e;
    for (int i = 0; i < 16; i++) begin
      if (i < sh)          e[i] = 1'b0;
      else if (i - sh < p) e[i] = v[i-sh];
      else                 e[i] = v[p-1];
    end
    return e;
  endfunction

  task automatic build(input int p, input int n, input int salt);
    for (int b = 0; b < 1024; b++) sbits[b] = 1'b0;
    for (int k = 0; k < n; k++) begin
      vals[k] = 16'((k * 37 + salt * 11 + 5) & ((1 << p) - 1));
      for (int b = 0; b < p; b++) sbits[k*p+b] = vals[k][b];
    end
    nvals  = n;
    nwords = (n * p + 15) / 16;
    for (int j = 0; j < nwords; j++)
      for (int b = 0; b < 16; b++) words[j][b] = sbits[j*16+b];
  endtask

  task automatic do_start(input int p, input int sh);
    @(negedge clk);
    cfg_len_m1 = 4'(p - 1);
    cfg_shift  = 4'(sh);
    start      = 1'b1;
    @(negedge clk);
    start      = 1'b0;
  endtask

  task automatic producer(input int first, input bit gaps);
    int idx = first;
    while (1) begin
      @(negedge clk);
      if (idx >= nwords) begin
        in_valid = 1'b0;
        break;
      end
      if (gaps && (cyc % 3 == 1)) begin
        in_valid = 1'b0;
      end else begin
        in_valid = 1'b1;
        in_word  = words[idx];
        if (in_ready) idx++;
      end
    end
  endtask

  task automatic consumer(input bit bp, input string tag, input int p, input int sh);
    int          got = 0;
    int          t   = 0;
    logic        stalled = 1'b0;
    logic [15:0] held = '0;
    logic        rdy;
    while (got < nvals && t < 3000) begin
      @(negedge clk);
      t++;
      if (stalled) chk("R9", {15'd0, out_valid, out_val}, {15'd0, 1'b1, held});
      rdy = !(bp && ((cyc % 4 == 2) || (cyc % 7 == 3)));
      out_ready = rdy;
      if (out_valid && rdy) begin
        chk(tag, {16'd0, out_val}, {16'd0, expand(vals[got], p, sh)});
        got++;
      end
      stalled = out_valid && !rdy;
      held    = out_val;
    end
    out_ready = 1'b1;
    chk(tag, 32'(got), 32'(nvals));
  endtask

  task automatic run_stream(input string tag, input int p, input int sh, input int n,
                            input int salt, input bit gaps, input bit bp, input bit scramble);
    build(p, n, salt);
    do_start(p, sh);
    if (scramble) begin
      // R3: configuration inputs move after capture
      cfg_len_m1 = ~4'(p - 1);
      cfg_shift  = ~4'(sh);
    end
    fork
      producer(0, gaps);
      consumer(bp, tag, p, sh);
    join
  endtask

  // R10: first value one edge after its word, then back-to-back output
  task automatic t_latency();
    build(4, 8, 3);
    do_start(4, 0);
    out_ready = 1'b1;
    in_valid  = 1'b1;
    in_word   = words[0];
    chk("R10", 32'(in_ready), 32'd1);
    @(negedge clk);
    in_word = words[1];
    chk("R10", 32'(out_valid), 32'd0);
    @(negedge clk);
    in_valid = 1'b0;
    for (int k = 0; k < 8; k++) begin
      chk("R10", {15'd0, out_valid, out_val}, {15'd0, 1'b1, expand(vals[k], 4, 0)});
      @(negedge clk);
    end
  endtask

  // R8: values wait for the word holding their last bit
  task automatic t_wait_field();
    int cnt = 0;
    build(10, 6, 4);
    do_start(10, 0);
    out_ready = 1'b1;
    for (int w = 0; w < 3; w++) begin
      in_valid = 1'b1;
      in_word  = words[w];
      @(negedge clk);
      in_valid = 1'b0;
      for (int c = 0; c < 6; c++) begin
        if (out_valid) begin
          chk("R8", {16'd0, out_val}, {16'd0, expand(vals[cnt], 10, 0)});
          cnt++;
        end
        @(negedge clk);
      end
      chk("R8", 32'(cnt), (w == 0) ? 32'd1 : (w == 1) ? 32'd3 : 32'd4);
      chk("R8", 32'(out_valid), 32'd0);
    end
  endtask

  // R7: input refused while both halves are in use and the slot is full
  task automatic t_full();
    int idx = 0;
    build(4, 16, 5);
    do_start(4, 0);
    out_ready = 1'b0;
    for (int c = 0; c < 10; c++) begin
      in_valid = 1'b1;
      in_word  = words[idx];
      if (in_ready) idx++;
      @(negedge clk);
    end
    chk("R7", 32'(idx), 32'd2);
    chk("R7", 32'(in_ready), 32'd0);
    chk("R9", {15'd0, out_valid, out_val}, {15'd0, 1'b1, expand(vals[0], 4, 0)});
    fork
      producer(2, 1'b0);
      consumer(1'b0, "R7", 4, 0);
    join
  endtask

  task automatic t_restart();
    do_start(5, 0);
    chk("R1", 32'(out_valid), 32'd0);
    chk("R1", 32'(in_ready), 32'd1);
  endtask

  initial begin
    wait (cyc >= 100000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=<100000", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst        = 1'b1;
    start      = 1'b0;
    cfg_len_m1 = '0;
    cfg_shift  = '0;
    in_word    = '0;
    in_valid   = 1'b0;
    out_ready  = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1", 32'(out_valid), 32'd0);
    chk("R1", 32'(in_ready), 32'd1);

    run_stream("R2", 3, 0, 40, 1, 1'b0, 1'b0, 1'b0);
    run_stream("R4", 5, 4, 30, 2, 1'b1, 1'b1, 1'b0);
    run_stream("R5", 7, 9, 30, 6, 1'b0, 1'b1, 1'b0);
    run_stream("R6", 1, 15, 33, 7, 1'b1, 1'b0, 1'b0);
    run_stream("R6", 11, 2, 20, 8, 1'b0, 1'b0, 1'b0);
    run_stream("R3", 16, 0, 20, 9, 1'b0, 1'b1, 1'b1);
    run_stream("R3", 6, 3, 25, 10, 1'b1, 1'b0, 1'b1);
    run_stream("R9", 9, 7, 24, 11, 1'b1, 1'b1, 1'b0);
    t_latency();
    t_wait_field();
    t_full();
    t_restart();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule